// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is the read path of a cache. It pairs a direct-mapped array of lines with a small fully associative victim buffer. A processor-side port accepts one byte address at a time and returns a 32-bit word along with a flag that says whether the word came from on-chip storage. A memory-side port fetches whole lines. It has one valid/ready handshake for the block request and a second one for the returned line data.

Each lookup tests only the one array line that the index field picks. If that line misses, the block number is compared against every victim entry at the same time. On a victim hit, the found entry and the line that sits at the index trade places, and the word is returned one cycle later than a plain hit. If the block is in neither structure, the whole line is fetched from memory and written into the array. A valid line pushed out of the array moves into the victim buffer and is not thrown away. When the buffer is full, the least recently used entry is overwritten.

Top module: `vc_cache_ctrl`

## Requirements
- R1: Field positions in the address: bits [OFF_W-1:2] pick a word in the line, where OFF_W = log2(WORDS_PER_LINE)+2. The next log2(LINES) bits are the array index, and the remaining top bits are the tag. The block number is address >> OFF_W. Word w of a line sits at bits [32w+31:32w] of the line data.
- R2: A request whose block is in the array returns its word with resp_hit=1 in the cycle after acceptance, and issues no memory request. Every accepted request produces exactly one single-cycle response.
- R3: A request whose block misses the array but is held in the victim buffer returns its word with resp_hit=1 two cycles after acceptance. req_ready is low for the cycle in between, and no memory request is issued.
- R4: A victim hit swaps the entries. The requested block then hits in the array, and the line it displaced becomes a victim entry that can hit later.
- R5: A request for a block held nowhere raises fill_req_valid with fill_req_block equal to the block number. The word is then returned with resp_hit=0 in the cycle after the line-data handshake, taken from the fetched line.
- R6: When a fetched line replaces a valid array line, the replaced line is placed in the victim buffer.
- R7: When all victim entries are valid, an insertion overwrites the entry used least recently. Both an insertion and a swap count as a use of the entry they write.
- R8: Reset clears every valid bit. After reset, req_ready=1, resp_valid=0, fill_req_valid=0, and the first access to any block is a miss.
- R9: From the acceptance of a missing request until its response, req_ready stays low and no new request is taken.
- R10: While fill_req_valid is high and fill_req_ready is low, fill_req_valid stays high and fill_req_block stays stable.
- R11: A block is never held in more than one place: at most one victim entry matches, and never a victim entry together with the array line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the requested word |
| resp_valid | output | 1 | Response word present (one cycle) |
| resp_hit | output | 1 | Word came from array or victim buffer |
| resp_data | output | 32 | Requested word |
| fill_req_valid | output | 1 | Line fetch request present |
| fill_req_ready | input | 1 | Memory takes the fetch request |
| fill_req_block | output | ADDR_W-OFF_W | Block number to fetch |
| fill_rsp_valid | input | 1 | Fetched line data present |
| fill_rsp_ready | output | 1 | Block waits for line data |
| fill_rsp_data | input | 32*WORDS_PER_LINE | Whole fetched line |

## Verification
The bench builds the block with a 10-bit address, four words per line, four array lines and two victim entries. With these sizes, blocks that share an index collide after a handful of requests, so array eviction, victim swaps and overwriting of the least recently used victim all come up early in both the directed sequence and a long random run over sixteen blocks. The small sizes also make it possible to vary the memory's request and data delays, and so to observe how long req_ready is held low and whether the fetch request stays stable.

// File: rtl/vc_pkg.sv
// Shared definitions for the victim-buffered read cache.
// Assumes: 32-bit words; nothing else is shared between modules.
package vc_pkg;
    localparam int WORD_BITS = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWAP  = 2'd1,
        ST_FREQ  = 2'd2,
        ST_FWAIT = 2'd3
    } vc_state_e;
endpackage

// File: rtl/vc_primary_store.sv
// Direct-mapped line array: one tag compare against the indexed line.
// Assumes: combinational read, one write port, valid bits cleared by reset.
module vc_primary_store #(
    parameter int LINES     = 2048,
    parameter int IDX_W     = 11,
    parameter int TAG_W     = 5,
    parameter int LINE_BITS = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     lk_index,
    input  logic [TAG_W-1:0]     lk_tag,
    output logic                 lk_hit,
    output logic                 lk_valid,
    output logic [TAG_W-1:0]     lk_tag_out,
    output logic [LINE_BITS-1:0] lk_line,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line
);
    logic [LINES-1:0]     valid_q;
    logic [TAG_W-1:0]     tag_q  [LINES];
    logic [LINE_BITS-1:0] line_q [LINES];

    // Read the indexed line and make the single tag comparison.
    always_comb begin
        lk_valid   = valid_q[lk_index];
        lk_tag_out = tag_q[lk_index];
        lk_line    = line_q[lk_index];
        lk_hit     = lk_valid && (lk_tag_out == lk_tag);
    end

    // Valid bits: cleared on reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_index] <= 1'b1;
    end

    // Tag and data storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_index]  <= wr_tag;
            line_q[wr_index] <= wr_line;
        end
    end
endmodule

// File: rtl/vc_victim_store.sv
// Fully associative victim buffer, compared in parallel on the block number.
// Keeps a recency rank per entry (0 = most recent) and offers a
// replacement way: the lowest invalid entry, else the least recent one.
// Assumes: ENTRIES >= 2; a valid write counts as a use of that entry.
module vc_victim_store #(
    parameter int ENTRIES   = 4,
    parameter int BLK_W     = 16,
    parameter int LINE_BITS = 512,
    localparam int WAY_W    = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BLK_W-1:0]     lk_block,
    output logic [ENTRIES-1:0]   lk_match,
    output logic                 lk_hit,
    output logic [WAY_W-1:0]     lk_way,
    output logic [LINE_BITS-1:0] lk_line,
    output logic [WAY_W-1:0]     repl_way,
    input  logic                 wr_en,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic                 wr_valid,
    input  logic [BLK_W-1:0]     wr_block,
    input  logic [LINE_BITS-1:0] wr_line
);
    logic [ENTRIES-1:0]   valid_q;
    logic [BLK_W-1:0]     blk_q  [ENTRIES];
    logic [LINE_BITS-1:0] line_q [ENTRIES];
    logic [WAY_W-1:0]     rank_q [ENTRIES];

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (blk_q[g] == lk_block);
    end

    // Encode the matching entry and pick its line.
    always_comb begin
        lk_way = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i]) lk_way = WAY_W'(i);
        lk_hit  = |lk_match;
        lk_line = line_q[lk_way];
    end

    // Replacement choice: first free entry, otherwise the oldest.
    always_comb begin
        logic found;
        found    = 1'b0;
        repl_way = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_q[i]) begin
                repl_way = WAY_W'(i);
                found    = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && rank_q[i] == WAY_W'(ENTRIES - 1)) begin
                repl_way = WAY_W'(i);
                found    = 1'b1;
            end
        end
    end

    // Valid bits follow the write port; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_way] <= wr_valid;
    end

    // Recency ranks: the written entry becomes newest, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= WAY_W'(i);
        end else if (wr_en && wr_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (WAY_W'(i) == wr_way)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[wr_way])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // Block numbers and line data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            blk_q[wr_way]  <= wr_block;
            line_q[wr_way] <= wr_line;
        end
    end
endmodule

// File: rtl/vc_cache_ctrl.sv
// Read cache controller: direct-mapped array backed by a victim buffer.
// Primary hit: word one cycle after acceptance. Victim hit: swap, word two
// cycles after acceptance. Full miss: fetch the line, park the displaced line
// in the victim buffer, then return the word with the hit flag low.
// Assumes: one request in flight beyond a hit; the memory returns a whole line.
module vc_cache_ctrl #(
    parameter int ADDR_W         = 22,
    parameter int WORDS_PER_LINE = 16,
    parameter int LINES          = 2048,
    parameter int VICTIMS        = 4,
    localparam int WSEL_W    = $clog2(WORDS_PER_LINE),
    localparam int OFF_W     = WSEL_W + 2,
    localparam int IDX_W     = $clog2(LINES),
    localparam int BLK_W     = ADDR_W - OFF_W,
    localparam int TAG_W     = BLK_W - IDX_W,
    localparam int LINE_BITS = vc_pkg::WORD_BITS * WORDS_PER_LINE,
    localparam int WAY_W     = $clog2(VICTIMS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [31:0]          resp_data,
    output logic                 fill_req_valid,
    input  logic                 fill_req_ready,
    output logic [BLK_W-1:0]     fill_req_block,
    input  logic                 fill_rsp_valid,
    output logic                 fill_rsp_ready,
    input  logic [LINE_BITS-1:0] fill_rsp_data
);
    import vc_pkg::*;

    vc_state_e            state_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [WAY_W-1:0]     way_q;

    logic [ADDR_W-1:0]    look_addr;
    logic [BLK_W-1:0]     look_blk;
    logic [IDX_W-1:0]     look_idx;
    logic [TAG_W-1:0]     look_tag;
    logic [WSEL_W-1:0]    look_word;
    logic                 accept;

    logic                 p_lk_hit, p_lk_valid;
    logic [TAG_W-1:0]     p_lk_tag_out;
    logic [LINE_BITS-1:0] p_lk_line;
    logic                 p_wr_en;
    logic [LINE_BITS-1:0] p_wr_line;

    logic [VICTIMS-1:0]   v_lk_match;
    logic                 v_lk_hit;
    logic [WAY_W-1:0]     v_lk_way, v_repl_way, v_wr_way;
    logic [LINE_BITS-1:0] v_lk_line;
    logic                 v_wr_en, v_wr_valid;

    logic                 fill_done;

    // Select one 32-bit word of a line.
    function automatic logic [31:0] pick_word(input logic [LINE_BITS-1:0] line,
                                              input logic [WSEL_W-1:0] w);
        return line[w*WORD_BITS +: WORD_BITS];
    endfunction

    // Lookup address: live request when idle, held address otherwise.
    always_comb begin
        look_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
        look_blk  = look_addr[ADDR_W-1:OFF_W];
        look_idx  = look_blk[IDX_W-1:0];
        look_tag  = look_blk[BLK_W-1:IDX_W];
        look_word = look_addr[OFF_W-1:2];
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign accept         = req_ready && req_valid;
    assign fill_req_valid = (state_q == ST_FREQ);
    assign fill_req_block = addr_q[ADDR_W-1:OFF_W];
    assign fill_rsp_ready = (state_q == ST_FWAIT);
    assign fill_done      = fill_rsp_ready && fill_rsp_valid;

    vc_primary_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_BITS(LINE_BITS)
    ) u_primary (
        .clk(clk), .rst_n(rst_n),
        .lk_index(look_idx), .lk_tag(look_tag),
        .lk_hit(p_lk_hit), .lk_valid(p_lk_valid),
        .lk_tag_out(p_lk_tag_out), .lk_line(p_lk_line),
        .wr_en(p_wr_en), .wr_index(look_idx), .wr_tag(look_tag),
        .wr_line(p_wr_line)
    );

    vc_victim_store #(
        .ENTRIES(VICTIMS), .BLK_W(BLK_W), .LINE_BITS(LINE_BITS)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .lk_block(look_blk), .lk_match(v_lk_match), .lk_hit(v_lk_hit),
        .lk_way(v_lk_way), .lk_line(v_lk_line), .repl_way(v_repl_way),
        .wr_en(v_wr_en), .wr_way(v_wr_way), .wr_valid(v_wr_valid),
        .wr_block({p_lk_tag_out, look_idx}), .wr_line(p_lk_line)
    );

    // Array and victim writes for swap and line fill.
    always_comb begin
        p_wr_en    = 1'b0;
        p_wr_line  = fill_rsp_data;
        v_wr_en    = 1'b0;
        v_wr_way   = v_repl_way;
        v_wr_valid = 1'b1;
        if (state_q == ST_SWAP) begin
            p_wr_en    = 1'b1;
            p_wr_line  = v_lk_line;
            v_wr_en    = 1'b1;
            v_wr_way   = way_q;
            v_wr_valid = p_lk_valid;
        end else if (fill_done) begin
            p_wr_en = 1'b1;
            v_wr_en = p_lk_valid;
        end
    end

    // Control sequence: idle, swap, fetch request, wait for line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            way_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q <= req_addr;
                    way_q  <= v_lk_way;
                    if (!p_lk_hit) state_q <= v_lk_hit ? ST_SWAP : ST_FREQ;
                end
                ST_SWAP:  state_q <= ST_IDLE;
                ST_FREQ:  if (fill_req_ready) state_q <= ST_FWAIT;
                ST_FWAIT: if (fill_rsp_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered response word and hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept && p_lk_hit) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b1;
                resp_data  <= pick_word(p_lk_line, look_word);
            end else if (state_q == ST_SWAP) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b1;
                resp_data  <= pick_word(v_lk_line, look_word);
            end else if (fill_done) begin
                resp_valid <= 1'b1;
                resp_hit   <= 1'b0;
                resp_data  <= pick_word(fill_rsp_data, look_word);
            end
        end
    end
endmodule

// File: rtl/vc_cache_checks.sv
// Protocol and placement properties for vc_cache_ctrl, attached by bind.
// Assumes: sampled on the rising clock, reset synchronous and active low.
module vc_cache_checks #(
    parameter int VICTIMS = 4,
    parameter int BLK_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               fill_req_valid,
    input logic               fill_req_ready,
    input logic [BLK_W-1:0]   fill_req_block,
    input logic               fill_rsp_valid,
    input logic               fill_rsp_ready,
    input logic               p_hit,
    input logic               v_hit,
    input logic [VICTIMS-1:0] v_match
);
    assert_primary_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && p_hit |=> resp_valid && resp_hit && !fill_req_valid);

    assert_victim_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !p_hit && v_hit
        |=> (!req_ready && !resp_valid && !fill_req_valid) ##1 (resp_valid && resp_hit));

    assert_miss_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !p_hit && !v_hit |=> fill_req_valid && !resp_valid);

    assert_fill_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_rsp_valid && fill_rsp_ready |=> resp_valid && !resp_hit);

    assert_cpu_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid || fill_rsp_ready) |-> !req_ready);

    assert_fill_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_req_block));

    assert_single_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_match) && !(p_hit && v_hit));
endmodule

bind vc_cache_ctrl vc_cache_checks #(.VICTIMS(VICTIMS), .BLK_W(BLK_W)) u_checks (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_block(fill_req_block),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_ready(fill_rsp_ready),
    .p_hit(p_lk_hit), .v_hit(v_lk_hit), .v_match(v_lk_match)
);

// File: tb/test_vc_cache_ctrl.sv
// Bench: behavioural reference (array of block numbers, recency queue of
// victims) drives expected hit kind, latency and word for every request.
module test_vc_cache_ctrl;
    localparam int ADDR_W = 10;
    localparam int WPL    = 4;
    localparam int LINES  = 4;
    localparam int VICT   = 2;
    localparam int OFF_W  = 4;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LBITS  = 32 * WPL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid, resp_hit;
    logic [31:0]       resp_data;
    logic              fill_req_valid;
    logic              fill_req_ready = 1'b0;
    logic [BLK_W-1:0]  fill_req_block;
    logic              fill_rsp_valid = 1'b0;
    logic              fill_rsp_ready;
    logic [LBITS-1:0]  fill_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_resp  = 0;
    int n_reqs  = 0;

    int       prim_blk [LINES];
    int       vq[$];

    always #5 clk = ~clk;

    vc_cache_ctrl #(.ADDR_W(ADDR_W), .WORDS_PER_LINE(WPL), .LINES(LINES),
                    .VICTIMS(VICT)) i_vc_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_block(fill_req_block),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_ready(fill_rsp_ready),
        .fill_rsp_data(fill_rsp_data)
    );

    function automatic logic [31:0] mem_word(int blk, int w);
        return {16'hC0DE, 8'(blk), 8'(w)};
    endfunction

    function automatic logic [LBITS-1:0] mem_line(int blk);
        logic [LBITS-1:0] l;
        for (int w = 0; w < WPL; w++) l[w*32 +: 32] = mem_word(blk, w);
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference: kind 0 array hit, 1 victim hit, 2 miss; updates the model.
    function automatic int predict(int blk);
        int idx = blk % LINES;
        int pos = -1;
        if (prim_blk[idx] == blk) return 0;
        foreach (vq[i]) if (vq[i] == blk) pos = i;
        if (pos >= 0) begin
            vq.delete(pos);
            if (prim_blk[idx] >= 0) vq.push_front(prim_blk[idx]);
            prim_blk[idx] = blk;
            return 1;
        end
        if (prim_blk[idx] >= 0) begin
            if (vq.size() == VICT) void'(vq.pop_back());
            vq.push_front(prim_blk[idx]);
        end
        prim_blk[idx] = blk;
        return 2;
    endfunction

    // One request; memory answers after hold/delay cycles.
    task automatic do_req(int addr, string req, int hold, int delay);
        int blk   = addr >> OFF_W;
        int w     = (addr >> 2) % WPL;
        int kind  = predict(blk);
        int lat   = 1;
        int phase = 0;
        int cnt   = 0;
        int exp_lat;
        @(negedge clk);
        check(req_ready === 1'b1, "R9", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        n_reqs++;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid && lat < 60) begin
            if (kind != 2)
                check(!fill_req_valid, "R2", "no fetch on hit", fill_req_valid, 0);
            else
                check(!req_ready, "R9", "ready low during fill", req_ready, 0);
            if (phase == 0 && fill_req_valid) begin
                check(fill_req_block == BLK_W'(blk), "R10", "fetch block", fill_req_block, blk);
                if (cnt == hold) begin
                    fill_req_ready = 1'b1;
                    phase = 1;
                    cnt   = 0;
                end else cnt++;
            end else if (phase == 1) begin
                fill_req_ready = 1'b0;
                if (cnt == delay) begin
                    fill_rsp_valid = 1'b1;
                    fill_rsp_data  = mem_line(blk);
                    phase = 2;
                end else cnt++;
            end
            @(negedge clk);
            lat++;
        end
        fill_rsp_valid = 1'b0;
        fill_req_ready = 1'b0;
        exp_lat = (kind == 0) ? 1 : (kind == 1) ? 2 : 3 + hold + delay;
        check(resp_valid === 1'b1, req, "response seen", resp_valid, 1);
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(resp_hit == (kind != 2), req, "hit flag", resp_hit, kind != 2);
        check(resp_data == mem_word(blk, w), req, "word (R1)", resp_data, mem_word(blk, w));
    endtask

    // Count single-cycle responses on every clock.
    always @(negedge clk) if (rst_n && resp_valid) n_resp++;

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        foreach (prim_blk[i]) prim_blk[i] = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R8", "ready after reset", req_ready, 1);
        check(resp_valid === 1'b0, "R8", "resp after reset", resp_valid, 0);
        check(fill_req_valid === 1'b0, "R8", "fetch after reset", fill_req_valid, 0);

        do_req('h004, "R8", 0, 0);   // first access misses
        do_req('h00C, "R2", 0, 0);   // same line, other word
        do_req('h040, "R6", 1, 2);   // same index, block 0 to victims
        do_req('h008, "R3", 0, 0);   // victim hit, swap
        do_req('h044, "R4", 0, 0);   // displaced line hits as victim
        do_req('h048, "R4", 0, 0);   // swapped block now an array hit
        do_req('h080, "R5", 2, 0);
        do_req('h0C0, "R7", 0, 1);   // buffer full, oldest dropped
        do_req('h004, "R7", 0, 0);   // dropped block misses
        do_req('h084, "R7", 0, 0);   // kept block still a victim hit
        do_req('h0C4, "R7", 0, 0);
        do_req('h104, "R7", 0, 0);
        do_req('h00C, "R7", 0, 0);
        do_req('h010, "R1", 0, 3);   // other indices are independent
        do_req('h020, "R1", 3, 0);
        do_req('h014, "R1", 0, 0);
        do_req('h02C, "R1", 0, 0);

        for (int i = 0; i < 300; i++)
            do_req(int'($urandom_range(0, 15)) * 16 + int'($urandom_range(0, 15)),
                   "R11", int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));

        @(negedge clk);
        check(n_resp == n_reqs, "R2", "one response per request", n_resp, n_reqs);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule